// File: doc/BRIEF.md
# Wide Synchronous Counter with Two-Level Lookahead Enables

The block is a 64-bit synchronous binary up counter with a count enable. It is built from eight 8-bit counter slices. Inside each slice every bit derives its toggle condition from one wide AND of the enable and all lower bits of that slice, so no gating chain runs through the slice. Each slice also raises a full flag, a plain AND of its own eight bits.

The slices form two 32-bit groups of four. Within a group, the enable of each slice is one wide AND of the group enable and the full flags of every lower slice in that group. The group also ANDs all four slice flags into a group-full flag. The upper group's enable is the lower group's enable ANDed with the lower group's full flag. That link is the only serial step in the enable path. A final carry reports the wrap from all ones to zero.

A synchronous active-high reset clears the count. A test preset input loads an arbitrary value in one edge, so that a bench can start the count near a slice or group boundary.

Top module: `wide_lookahead_counter`

## Requirements
- R1: When `rst` is 1 at a rising edge, `count` becomes 0 on that edge. This holds whatever the values of `en` and `preset_en`.
- R2: When `rst` and `preset_en` are 0 and `en` is 1 at a rising edge, `count` becomes its previous value plus one, modulo 2^64.
- R3: When `rst`, `preset_en` and `en` are all 0 at a rising edge, `count` keeps its value.
- R4: `carry_out` is 1 exactly when `en` is 1 and all 64 bits of `count` are 1. On the next counting edge, `count` wraps to 0.
- R5: When the low 8-bit slice is all ones (0xFF) and the count is enabled, the carry passes into the next slice, so 0xFF becomes 0x100.
- R6: The carry crosses between the two 32-bit groups. 0x00000000_FFFFFFFF becomes 0x00000001_00000000 in one edge, and counting continues normally beyond it.
- R7: The carry crosses slice boundaries inside either group. 0x00FFFFFF becomes 0x01000000, and 0x0000FFFF_FFFFFFFF becomes 0x00010000_00000000. A value one short of all ones (0xFFFF_FFFF_FFFF_FFFE) gives `carry_out` = 0.
- R8: When `rst` is 0 and `preset_en` is 1 at a rising edge, `count` takes the value of `preset_val`. This overrides `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears the count |
| en | input | 1 | Count enable |
| preset_en | input | 1 | Test preset strobe, loads `preset_val` |
| preset_val | input | 64 | Value loaded by the preset |
| count | output | 64 | Registered count value |
| carry_out | output | 1 | High when enabled at all ones (wrap) |

## Verification
The checker tests the following on every cycle:
- Each enabled edge adds exactly one.
- Each disabled edge holds the count.
- The carry matches the enable and the all-ones state.
- An asserted carry is followed by zero.
- Reset and preset results land on the next edge.

These properties cannot show that particular boundary crossings take place. Only the bench's scenarios can show that, by starting the count just below each one:
- a slice edge inside a group,
- the serial link between the groups,
- the full 64-bit wrap,
- the values one short of a boundary, where the carry must stay low.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  parameter int DEF_SLICE_W = 8;
  parameter int DEF_SLICES_PER_GRP = 4;
  parameter int DEF_GROUPS = 2;

  // mask with the n lowest bits set (n <= 63)
  function automatic logic [63:0] low_mask(input int n);
    return (64'(1) << n) - 64'(1);
  endfunction
endpackage

// File: rtl/wlc_slice.sv
module wlc_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         full
);
  logic [W-1:0] q_r;
  logic [W-1:0] tgl;

  // parallel gating: each bit looks at all lower bits through one AND
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [W-1:0] LOWER = W'(wlc_pkg::low_mask(i));
    assign tgl[i] = en & (&(q_r | ~LOWER));
  end

  always_ff @(posedge clk) begin
    if (rst)        q_r <= '0;
    else if (ld_en) q_r <= ld_val;
    else            q_r <= q_r ^ tgl;
  end

  assign q    = q_r;
  assign full = &q_r;  // not qualified by en
endmodule

// File: rtl/wlc_group.sv
module wlc_group #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           grp_en,
  input  logic           ld_en,
  input  logic [N*W-1:0] ld_val,
  output logic [N*W-1:0] q,
  output logic           grp_full
);
  logic [N-1:0] flags;
  logic [N-1:0] sl_en;

  for (genvar k = 0; k < N; k++) begin : g_slice
    localparam logic [N-1:0] LOWER = N'(wlc_pkg::low_mask(k));
    // one wide AND over the group enable and every lower slice flag
    assign sl_en[k] = grp_en & (&(flags | ~LOWER));

    wlc_slice #(.W(W)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .en     (sl_en[k]),
      .ld_en  (ld_en),
      .ld_val (ld_val[k*W +: W]),
      .q      (q[k*W +: W]),
      .full   (flags[k])
    );
  end

  assign grp_full = &flags;
endmodule

// File: rtl/wide_lookahead_counter.sv
module wide_lookahead_counter #(
  parameter int SLICE_W        = wlc_pkg::DEF_SLICE_W,
  parameter int SLICES_PER_GRP = wlc_pkg::DEF_SLICES_PER_GRP,
  parameter int GROUPS         = wlc_pkg::DEF_GROUPS
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      en,
  input  logic                                      preset_en,
  input  logic [SLICE_W*SLICES_PER_GRP*GROUPS-1:0]  preset_val,
  output logic [SLICE_W*SLICES_PER_GRP*GROUPS-1:0]  count,
  output logic                                      carry_out
);
  localparam int GRP_W = SLICE_W * SLICES_PER_GRP;

  logic [GROUPS:0]   chain;
  logic [GROUPS-1:0] gfull;

  assign chain[0] = en;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    wlc_group #(.W(SLICE_W), .N(SLICES_PER_GRP)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .grp_en   (chain[g]),
      .ld_en    (preset_en),
      .ld_val   (preset_val[g*GRP_W +: GRP_W]),
      .q        (count[g*GRP_W +: GRP_W]),
      .grp_full (gfull[g])
    );
    // serial link between groups
    assign chain[g+1] = chain[g] & gfull[g];
  end

  assign carry_out = chain[GROUPS];
endmodule

// File: rtl/wlc_checker.sv
module wlc_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         preset_en,
  input logic [W-1:0] preset_val,
  input logic [W-1:0] count,
  input logic         carry_out
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> count == '0);

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (en && !preset_en) |=> count == $past(count) + W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !preset_en) |=> $stable(count));

  a_r4_carry_flag: assert property (@(posedge clk) disable iff (rst)
    carry_out == (en && (&count)));

  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (carry_out && !preset_en) |=> count == '0);

  a_r8_preset_load: assert property (@(posedge clk) disable iff (rst)
    preset_en |=> count == $past(preset_val));
endmodule

bind wide_lookahead_counter wlc_checker #(.W(SLICE_W*SLICES_PER_GRP*GROUPS)) u_wlc_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .preset_en  (preset_en),
  .preset_val (preset_val),
  .count      (count),
  .carry_out  (carry_out)
);

// File: tb/wide_lookahead_counter_bench.sv
module wide_lookahead_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        preset_en = 1'b0;
  logic [63:0] preset_val = '0;
  logic [63:0] count;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wide_lookahead_counter u_wide_lookahead_counter (
    .clk(clk), .rst(rst), .en(en), .preset_en(preset_en),
    .preset_val(preset_val), .count(count), .carry_out(carry_out)
  );

  // {start, en, expected next, expected carry}
  localparam int NV = 9;
  localparam logic [129:0] VEC [NV] = '{
    {64'h0000000000000000, 1'b1, 64'h0000000000000001, 1'b0},  // R2
    {64'h00000000000000FF, 1'b1, 64'h0000000000000100, 1'b0},  // R5
    {64'h0000000000FFFFFF, 1'b1, 64'h0000000001000000, 1'b0},  // R7
    {64'h00000000FFFFFFFF, 1'b1, 64'h0000000100000000, 1'b0},  // R6
    {64'h0000FFFFFFFFFFFF, 1'b1, 64'h0001000000000000, 1'b0},  // R7
    {64'hFFFFFFFFFFFFFFFF, 1'b1, 64'h0000000000000000, 1'b1},  // R4
    {64'hFFFFFFFFFFFFFFFF, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b0},  // R3/R4
    {64'hFFFFFFFFFFFFFFFE, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b0},  // R7
    {64'h123456789ABCDEF0, 1'b0, 64'h123456789ABCDEF0, 1'b0}   // R3
  };
  localparam string VTAG [NV] = '{"R2", "R5", "R7", "R6", "R7", "R4", "R3", "R7", "R3"};

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s count act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s carry act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [63:0] v);
    preset_en  = 1'b1;
    preset_val = v;
    en         = 1'b0;
    tick();
    preset_en  = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    en  = 1'b1;
    tick();
    tick();
    chk64("R1", count, 64'h0);
    rst = 1'b0;
    en  = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      load(VEC[v][129:66]);
      chk64("R8", count, VEC[v][129:66]);
      en = VEC[v][65];
      #1;
      chk1(VTAG[v], carry_out, VEC[v][0]);
      @(negedge clk);
      chk64(VTAG[v], count, VEC[v][64:1]);
      en = 1'b0;
    end

    // multi-cycle count across the group link
    load(64'h00000000FFFFFFFE);
    en = 1'b1;
    for (int c = 0; c < 4; c++) tick();
    chk64("R6", count, 64'h0000000100000002);

    // hold over several edges
    en = 1'b0;
    for (int c = 0; c < 3; c++) tick();
    chk64("R3", count, 64'h0000000100000002);

    // preset wins over enable
    preset_en  = 1'b1;
    preset_val = 64'hA5A5A5A5A5A5A5A5;
    en         = 1'b1;
    tick();
    chk64("R8", count, 64'hA5A5A5A5A5A5A5A5);
    preset_en = 1'b0;
    tick();
    chk64("R2", count, 64'hA5A5A5A5A5A5A5A6);

    // reset wins over preset and enable
    rst        = 1'b1;
    preset_en  = 1'b1;
    preset_val = 64'h1;
    tick();
    chk64("R1", count, 64'h0);
    rst       = 1'b0;
    preset_en = 1'b0;
    en        = 1'b0;
    tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule